// File: doc/BRIEF.md
# Qualified Pattern Trigger Detector

This block watches a 24-bit sample bus in a logic-capture front end and decides when to start capture. The upper 12 bits of each sample are compared by magnitude against a reference value. The lower 12 bits are compared for equality against a second reference, and a mask marks the bits whose value does not matter. The trigger condition is true only when both comparisons are true in the same cycle.

The combined condition has to hold for a programmable number of consecutive sample clocks before the block fires. If the condition drops for even one cycle, the block starts counting again. This lets the block ignore glitches shorter than a minimum stable time. For example, 1 µs at the nominal 25 MHz sample clock is a qualification length of 24.

Software arms the block. It then produces one single-cycle trigger pulse and holds a triggered status until it is cleared. A new capture needs a clear followed by a new arm.

Top module: `qual_trigger`

## Requirements
- R1: After reset, the outputs `trig_pulse`, `triggered` and `armed` are all low and the block is idle.
- R2: In the idle state, `arm` high at a clock edge makes `armed` high from the next cycle. `armed` stays high while the block waits or qualifies, and `arm` has no effect in any other state.
- R3: The magnitude field is `sample[23:12]`. It is compared unsigned against `mag_ref` using `mag_mode`: 0 greater-than, 1 less-than, 2 greater-or-equal, 3 less-or-equal.
- R4: The equality field is `sample[11:0]`. It matches `eq_ref` when every bit is equal or has its bit set in `eq_mask` (1 = don't care).
- R5: While armed, the trigger fires at the clock edge where the combined condition has been true for `qual_len`+1 consecutive samples, counting that edge's sample.
- R6: A sample with the combined condition false, while qualifying, resets the count. Qualification restarts from one on the next true sample.
- R7: With `qual_len` = 0, the first true sample after arming fires the trigger.
- R8: `trig_pulse` is high for exactly one cycle, the cycle after the deciding edge.
- R9: `triggered` rises together with `trig_pulse` and stays high until `clear`. While triggered, further matching samples and `arm` produce no pulse.
- R10: `clear` at an edge returns the block to idle from any state. It wins over `arm` and over a qualification that would expire at the same edge.
- R11: While idle, matching samples have no effect: no pulse, no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 24 | Monitored sample bus |
| mag_ref | input | 12 | Reference for magnitude field |
| mag_mode | input | 2 | Magnitude comparison code |
| eq_ref | input | 12 | Reference for equality field |
| eq_mask | input | 12 | Don't-care mask, 1 ignores the bit |
| qual_len | input | 16 | Extra consecutive true cycles required |
| arm | input | 1 | Arm request from idle |
| clear | input | 1 | Return to idle |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Trigger has fired and is held |
| armed | output | 1 | Waiting for or qualifying the condition |

## Verification
Two events can meet at one clock edge: a `clear` and the expiry of a qualification count. Arm and clear can also arrive together. The bench lines up a clear with the exact edge on which a held match would fire. It judges that no pulse appears and that both status flags drop. It also drives arm and clear together from idle and expects the block to stay idle. A behavioural model, run every cycle through randomised runs with short qualification lengths and frequent clears, catches other coincidences.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        MAG_GT = 2'd0,
        MAG_LT = 2'd1,
        MAG_GE = 2'd2,
        MAG_LE = 2'd3
    } mag_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_QUAL  = 2'd2,
        ST_TRIG  = 2'd3
    } trig_state_e;
endpackage

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
#(
    parameter int FIELD_W = 12
) (
    input  logic [FIELD_W-1:0] mag_field,
    input  logic [FIELD_W-1:0] mag_ref,
    input  logic [1:0]         mag_mode,
    input  logic [FIELD_W-1:0] eq_field,
    input  logic [FIELD_W-1:0] eq_ref,
    input  logic [FIELD_W-1:0] eq_mask,
    output logic               mag_hit,
    output logic               eq_hit
);
    logic [FIELD_W-1:0] bit_ok;

    // R4: per-bit match, masked bits always match
    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        assign bit_ok[i] = eq_mask[i] | (eq_field[i] ~^ eq_ref[i]);
    end
    assign eq_hit = &bit_ok;

    // R3: unsigned magnitude compare, selected by mode
    always_comb begin
        unique case (mag_mode_e'(mag_mode))
            MAG_GT:  mag_hit = mag_field >  mag_ref;
            MAG_LT:  mag_hit = mag_field <  mag_ref;
            MAG_GE:  mag_hit = mag_field >= mag_ref;
            MAG_LE:  mag_hit = mag_field <= mag_ref;
            default: mag_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
    import trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond,
    input  logic             arm,
    input  logic             clear,
    input  logic [CNT_W-1:0] qual_len,
    output logic             trig_pulse,
    output logic             triggered,
    output logic             armed
);
    typedef struct packed {
        trig_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (clear) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (arm) r_d.state = ST_ARMED;
                end
                ST_ARMED: begin
                    if (cond) begin
                        if (qual_len == '0) begin
                            r_d.state = ST_TRIG;
                            r_d.pulse = 1'b1;
                        end else begin
                            r_d.state = ST_QUAL;
                            r_d.cnt   = CNT_W'(1);
                        end
                    end
                end
                ST_QUAL: begin
                    if (!cond) begin
                        r_d.state = ST_ARMED;
                        r_d.cnt   = '0;
                    end else if (r_q.cnt >= qual_len) begin
                        r_d.state = ST_TRIG;
                        r_d.pulse = 1'b1;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_TRIG: ;
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trig_pulse = r_q.pulse;
    assign triggered  = (r_q.state == ST_TRIG);
    assign armed      = (r_q.state == ST_ARMED) || (r_q.state == ST_QUAL);

    // R8: pulse never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
    // R9: pulse only alongside the held status
    a_r9_pulse_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> triggered);
    // R9: status holds until clear
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !clear) |=> triggered);
    // R10: clear returns to idle
    a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!triggered && !armed && !trig_pulse));
    // R11: idle without arm stays idle
    a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !triggered && !arm) |=> (!armed && !triggered));
    // R6: a false sample while qualifying never fires
    a_r6_false_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cond) |=> !trig_pulse);
endmodule

// File: rtl/qual_trigger.sv
module qual_trigger #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 16,
    localparam int HALF_W  = SAMPLE_W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [HALF_W-1:0]   mag_ref,
    input  logic [1:0]          mag_mode,
    input  logic [HALF_W-1:0]   eq_ref,
    input  logic [HALF_W-1:0]   eq_mask,
    input  logic [CNT_W-1:0]    qual_len,
    input  logic                arm,
    input  logic                clear,
    output logic                trig_pulse,
    output logic                triggered,
    output logic                armed
);
    logic mag_hit, eq_hit;

    trig_cmp #(.FIELD_W(HALF_W)) u_cmp (
        .mag_field (sample[SAMPLE_W-1:HALF_W]),
        .mag_ref   (mag_ref),
        .mag_mode  (mag_mode),
        .eq_field  (sample[HALF_W-1:0]),
        .eq_ref    (eq_ref),
        .eq_mask   (eq_mask),
        .mag_hit   (mag_hit),
        .eq_hit    (eq_hit)
    );

    trig_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond       (mag_hit & eq_hit),
        .arm        (arm),
        .clear      (clear),
        .qual_len   (qual_len),
        .trig_pulse (trig_pulse),
        .triggered  (triggered),
        .armed      (armed)
    );
endmodule

// File: tb/tb_qual_trigger.sv
module tb_qual_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] sample = '0;
    logic [11:0] mag_ref = '0, eq_ref = '0, eq_mask = '0;
    logic [1:0]  mag_mode = '0;
    logic [15:0] qual_len = '0;
    logic        arm = 1'b0, clear = 1'b0;
    logic        trig_pulse, triggered, armed;

    int tests = 0, fails = 0, pulses_seen = 0;
    bit finished = 0;

    // behavioural model: 0 idle, 1 waiting, 2 qualifying, 3 fired
    int m_st = 0, m_run = 0;
    bit m_pulse = 0;

    always #2 clk = ~clk;

    qual_trigger dut (.*);

    function automatic bit model_cond();
        int a, r;
        bit mag;
        a = int'(sample[23:12]);
        r = int'(mag_ref);
        case (mag_mode)
            2'd0: mag = a > r;
            2'd1: mag = a < r;
            2'd2: mag = a >= r;
            default: mag = a <= r;
        endcase
        return mag && (((sample[11:0] ^ eq_ref) & ~eq_mask) == 12'd0);
    endfunction

    always @(posedge clk) begin
        bit c;
        c = model_cond();
        m_pulse = 0;
        if (!rst_n) begin m_st = 0; m_run = 0; end
        else if (clear) begin m_st = 0; m_run = 0; end
        else if (m_st == 0) begin if (arm) m_st = 1; end
        else if (m_st == 1 || m_st == 2) begin
            if (!c) begin m_st = 1; m_run = 0; end
            else begin
                m_run++;
                if (m_run > int'(qual_len)) begin m_st = 3; m_pulse = 1; m_run = 0; end
                else m_st = 2;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (trig_pulse) pulses_seen++;
            check(trig_pulse === m_pulse, "R8 pulse vs model", trig_pulse, m_pulse);
            check(triggered === (m_st == 3), "R9 status vs model", triggered, m_st == 3);
            check(armed === (m_st == 1 || m_st == 2), "R2 armed vs model", armed, m_st == 1 || m_st == 2);
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        clear = 1; tick(); clear = 0;
    endtask

    task automatic do_arm();
        arm = 1; tick(); arm = 0;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            fails++; tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int p0;
        tick(3);
        check(!trig_pulse && !triggered && !armed, "R1 reset outputs", {trig_pulse, triggered, armed}, 0);
        rst_n = 1;
        tick();
        check(!armed && !triggered, "R1 idle after reset", {triggered, armed}, 0);

        // R11: match while idle does nothing
        mag_ref = 12'h400; eq_ref = 12'h0A5; eq_mask = 12'h000; mag_mode = 2'd2; qual_len = 0;
        sample = {12'h400, 12'h0A5};
        p0 = pulses_seen;
        tick(5);
        check(pulses_seen == p0 && !triggered && !armed, "R11 idle ignores match", pulses_seen - p0, 0);

        // R3: all four modes at equality boundary and one step away
        for (int m = 0; m < 4; m++) begin
            for (int d = -1; d <= 1; d++) begin
                bit exp;
                do_clear();
                mag_mode = 2'(m);
                sample = {12'(32'h400 + d), 12'h0A5};
                exp = (m == 0) ? d > 0 : (m == 1) ? d < 0 : (m == 2) ? d >= 0 : d <= 0;
                do_arm();
                tick(3);
                check(triggered == exp, "R3 magnitude mode", triggered, exp);
            end
        end

        // R4: masked bits ignored, unmasked mismatch blocks
        mag_mode = 2'd2; sample = {12'h400, 12'h0F5};
        do_clear(); eq_mask = 12'h050; do_arm(); tick(3);
        check(triggered == 1, "R4 masked bits match", triggered, 1);
        do_clear(); eq_mask = 12'h040; do_arm(); tick(3);
        check(triggered == 0, "R4 unmasked mismatch", triggered, 0);
        eq_mask = 0; sample = {12'h400, 12'h0A5};

        // R5/R8: qual_len 3 needs 4 consecutive true samples
        do_clear(); qual_len = 3; sample = 0; do_arm();
        sample = {12'h400, 12'h0A5};
        tick(3);
        check(!triggered, "R5 not yet after 3 samples", triggered, 0);
        tick();
        check(trig_pulse && triggered, "R5 fires after 4 samples", trig_pulse, 1);
        tick();
        check(!trig_pulse && triggered, "R8 pulse one cycle", trig_pulse, 0);
        p0 = pulses_seen;
        do_arm(); tick(6);
        check(pulses_seen == p0 && triggered, "R9 no retrigger, arm ignored", pulses_seen - p0, 0);

        // R6: glitch resets count
        do_clear(); do_arm();
        sample = {12'h400, 12'h0A5}; tick(3);
        sample = 0; tick();
        sample = {12'h400, 12'h0A5}; tick(3);
        check(!triggered && armed, "R6 restart after glitch", triggered, 0);
        tick();
        check(triggered, "R6 fires after full rerun", triggered, 1);

        // R7: zero length fires on first true sample
        do_clear(); qual_len = 0; sample = 0; do_arm();
        sample = {12'h400, 12'h0A5}; tick();
        check(trig_pulse, "R7 zero length immediate", trig_pulse, 1);

        // R10: clear on the expiring edge
        do_clear(); qual_len = 2; sample = {12'h400, 12'h0A5};
        p0 = pulses_seen;
        arm = 1; tick(); arm = 0;
        tick(2);
        clear = 1; tick(); clear = 0;
        check(!triggered && !armed && pulses_seen == p0, "R10 clear beats expiry", triggered, 0);
        arm = 1; clear = 1; tick(); arm = 0; clear = 0;
        check(!armed, "R10 clear beats arm", armed, 0);

        // randomised run against the model
        for (int i = 0; i < 4000; i++) begin
            qual_len = 16'($urandom_range(0, 4));
            mag_mode = 2'($urandom_range(0, 3));
            eq_mask = ($urandom_range(0, 3) == 0) ? 12'hFFF : 12'($urandom);
            sample = {12'($urandom_range(12'h3FE, 12'h402)),
                      ($urandom_range(0, 2) == 0) ? 12'($urandom) : 12'h0A5};
            arm = ($urandom_range(0, 5) == 0);
            clear = ($urandom_range(0, 20) == 0);
            tick();
        end
        arm = 0; clear = 0; tick(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule